// File: doc/BRIEF.md
# Bus Trace Capture Controller

This block watches a bus one cycle at a time and writes selected cycles into a small circular trace memory. The memory itself sits outside the block; the block drives its write port (enable, address, entry word) and keeps the write pointer and a count of valid entries. A filter setting picks which cycles become entries: changes of flow only, changes of flow with back-to-back repeats of the same source address dropped, or every real data cycle with free cycles and opcode fetches left out.

A placement setting fixes where the capture window sits around the final-state trigger from the sequencer. With leading placement, recording starts at the trigger and fills the memory once. With centred placement, recording runs before the trigger and keeps going for half the depth after it. With trailing placement, recording runs before the trigger and stops at the trigger. An arm pulse starts a session, clears the pointer, the count, the repeat history and the done flag, and latches both settings. A done flag reports that recording has stopped.

Top module: `bus_trace_recorder`

## Requirements
- R1: While reset is held and after reset until the first arm, `bufWrEn`, `bufWrAddr`, `bufWrData`, `wrPtr`, `validCount` and `sessionDone` are all zero and no entry is written.
- R2: With `traceMode` 00 (or 11), a cycle is stored only when `busValid` and `cofFlag` are both high. The entry is `{1'b0, cofSrcAddr, busAddr}`, with `busAddr` resized to DATA_W. The write port presents it on the clock edge after the cycle in which the bus was sampled.
- R3: With `traceMode` 01, entries follow R2 except for one case. A change of flow whose `cofSrcAddr` equals the source address of the last entry stored in this session is not stored. The first change of flow after an arm is always eligible.
- R4: With `traceMode` 10, every cycle with `busValid` high and both `freeCycle` and `opFetch` low is stored. The entry is `{1'b1, busAddr, busData}`.
- R5: With `align` 00, nothing is stored before `trigIn`. Storing begins with the trigger cycle itself and stops once DEPTH entries have been stored.
- R6: With `align` 01, storing starts at arm. From the trigger cycle onward, DEPTH/2 more entries are stored (the trigger cycle's entry counts if it qualifies), and then storing stops.
- R7: With `align` 10 (or 11), storing starts at arm and wraps freely. It stops after the trigger cycle, whose entry is stored if it qualifies.
- R8: `bufWrAddr` takes successive values modulo DEPTH, and `wrPtr` always names the next slot. `validCount` rises by one per entry and saturates at DEPTH.
- R9: `sessionDone` goes high on the edge that ends recording. After that no entry is written until the next arm, and an arm clears `sessionDone` on the following edge.
- R10: `traceMode` and `align` are sampled only in the arm cycle, and later changes have no effect on the session. `trigIn` has no effect while idle, during post-trigger recording, or after the session is done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Starts a new session; latches mode and placement |
| traceMode | input | 2 | 00 change of flow, 01 change of flow without repeats, 10 detail, 11 as 00 |
| align | input | 2 | 00 leading, 01 centred, 10 trailing, 11 as 10 |
| trigIn | input | 1 | Final-state trigger from the sequencer |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | ADDR_W | Cycle address (destination for a change of flow) |
| busData | input | DATA_W | Cycle data |
| cofFlag | input | 1 | This cycle is a change of flow |
| freeCycle | input | 1 | This cycle is a free cycle |
| opFetch | input | 1 | This cycle is an opcode fetch |
| cofSrcAddr | input | ADDR_W | Source address of the change of flow |
| bufWrEn | output | 1 | Trace memory write enable |
| bufWrAddr | output | log2(DEPTH) | Trace memory write address |
| bufWrData | output | 1+ADDR_W+DATA_W | Entry word: kind bit, address field, data field |
| wrPtr | output | log2(DEPTH) | Next slot to be written |
| validCount | output | log2(DEPTH)+1 | Valid entries, saturating at DEPTH |
| sessionDone | output | 1 | Recording has stopped for this session |

## Verification
The bench builds the block with DEPTH set to 8 and 16-bit address and data fields. A depth of 8 means pointer wrap, count saturation and the centred stop point after four entries all occur many times within a short session. Source addresses are drawn from only four values, so repeated sources in the repeat-suppressing mode are common. The bench goes through every combination of mode and placement, including the two reserved codes, and changes both settings during sessions. It also pulses the trigger in every controller state.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

  typedef enum logic [1:0] {
    MODE_COF    = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_DETAIL = 2'b10,
    MODE_RSVD   = 2'b11
  } traceMode_e;

  typedef enum logic [1:0] {
    ALIGN_BEGIN = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_END   = 2'b10,
    ALIGN_RSVD  = 2'b11
  } align_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearAll;
    logic       captureOpen;
    traceMode_e mode;
  } capStrobe_t;

endpackage

// File: rtl/trace_cap_datapath.sv
module trace_cap_datapath
  import trace_cap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int ENTRY_W = 1 + ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         strobe,
  input  logic               busValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  input  logic               cofFlag,
  input  logic               freeCycle,
  input  logic               opFetch,
  input  logic [ADDR_W-1:0]  cofSrcAddr,
  output logic               hit,
  output logic               bufWrEn,
  output logic [PTR_W-1:0]   bufWrAddr,
  output logic [ENTRY_W-1:0] bufWrData,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [CNT_W-1:0]   validCount
);

  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0]  lastSrc;
  logic               histValid;
  logic               repeatSrc;
  logic               doWrite;
  logic [ENTRY_W-1:0] entryWord;

  assign repeatSrc = histValid && (cofSrcAddr == lastSrc);

  always_comb begin
    unique case (strobe.mode)
      MODE_DETAIL: hit = busValid && !freeCycle && !opFetch;
      MODE_LOOP:   hit = busValid && cofFlag && !repeatSrc;
      default:     hit = busValid && cofFlag;
    endcase
  end

  always_comb begin
    if (strobe.mode == MODE_DETAIL)
      entryWord = {1'b1, busAddr, busData};
    else
      entryWord = {1'b0, cofSrcAddr, DATA_W'(busAddr)};
  end

  assign doWrite = strobe.captureOpen && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn    <= 1'b0;
      bufWrAddr  <= '0;
      bufWrData  <= '0;
      wrPtr      <= '0;
      validCount <= '0;
      lastSrc    <= '0;
      histValid  <= 1'b0;
    end else if (strobe.clearAll) begin
      bufWrEn    <= 1'b0;
      wrPtr      <= '0;
      validCount <= '0;
      histValid  <= 1'b0;
    end else begin
      bufWrEn <= doWrite;
      if (doWrite) begin
        bufWrAddr <= wrPtr;
        bufWrData <= entryWord;
        wrPtr     <= wrPtr + 1'b1;
        if (validCount != FULL_COUNT)
          validCount <= validCount + 1'b1;
        if (strobe.mode == MODE_LOOP) begin
          lastSrc   <= cofSrcAddr;
          histValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trace_cap_control.sv
module trace_cap_control
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic [1:0] traceMode,
  input  logic [1:0] align,
  input  logic       trigIn,
  input  logic       hit,
  output capStrobe_t strobe,
  output logic       sessionDone
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_POST, ST_DONE
  } capState_e;

  localparam logic [CNT_W-1:0] LIMIT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LIMIT_HALF = CNT_W'(DEPTH / 2);

  capState_e        st, stNext;
  logic [CNT_W-1:0] postCnt, cntNext, postLimit;
  align_e           alignQ;
  traceMode_e       modeQ;
  logic             endAligned;

  assign postLimit  = (alignQ == ALIGN_BEGIN) ? LIMIT_FULL : LIMIT_HALF;
  assign endAligned = (alignQ == ALIGN_END) || (alignQ == ALIGN_RSVD);

  always_comb begin
    stNext  = st;
    cntNext = postCnt;
    if (arm) begin
      stNext  = (align_e'(align) == ALIGN_BEGIN) ? ST_WAIT : ST_PRE;
      cntNext = '0;
    end else begin
      unique case (st)
        ST_WAIT, ST_PRE: begin
          if (trigIn) begin
            if (st == ST_PRE && endAligned) begin
              stNext = ST_DONE;
            end else begin
              cntNext = {{(CNT_W-1){1'b0}}, hit};
              stNext  = (hit && postLimit == CNT_W'(1)) ? ST_DONE : ST_POST;
            end
          end
        end
        ST_POST: begin
          if (hit) begin
            cntNext = postCnt + 1'b1;
            if (cntNext == postLimit) stNext = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      postCnt <= '0;
      alignQ  <= ALIGN_BEGIN;
      modeQ   <= MODE_COF;
    end else begin
      st      <= stNext;
      postCnt <= cntNext;
      if (arm) begin
        alignQ <= align_e'(align);
        modeQ  <= traceMode_e'(traceMode);
      end
    end
  end

  assign strobe.clearAll    = arm;
  assign strobe.captureOpen = !arm && ((st == ST_PRE) || (st == ST_POST) ||
                                       (st == ST_WAIT && trigIn));
  assign strobe.mode        = modeQ;
  assign sessionDone        = (st == ST_DONE);

endmodule

// File: rtl/bus_trace_recorder.sv
module bus_trace_recorder
  import trace_cap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int ENTRY_W = 1 + ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arm,
  input  logic [1:0]         traceMode,
  input  logic [1:0]         align,
  input  logic               trigIn,
  input  logic               busValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  input  logic               cofFlag,
  input  logic               freeCycle,
  input  logic               opFetch,
  input  logic [ADDR_W-1:0]  cofSrcAddr,
  output logic               bufWrEn,
  output logic [PTR_W-1:0]   bufWrAddr,
  output logic [ENTRY_W-1:0] bufWrData,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [CNT_W-1:0]   validCount,
  output logic               sessionDone
);

  capStrobe_t strobe;
  logic       hit;

  trace_cap_control #(.DEPTH(DEPTH)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .arm        (arm),
    .traceMode  (traceMode),
    .align      (align),
    .trigIn     (trigIn),
    .hit        (hit),
    .strobe     (strobe),
    .sessionDone(sessionDone)
  );

  trace_cap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busValid  (busValid),
    .busAddr   (busAddr),
    .busData   (busData),
    .cofFlag   (cofFlag),
    .freeCycle (freeCycle),
    .opFetch   (opFetch),
    .cofSrcAddr(cofSrcAddr),
    .hit       (hit),
    .bufWrEn   (bufWrEn),
    .bufWrAddr (bufWrAddr),
    .bufWrData (bufWrData),
    .wrPtr     (wrPtr),
    .validCount(validCount)
  );

endmodule

// File: rtl/trace_cap_checker.sv
module trace_cap_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int ENTRY_W = 1 + ADDR_W + DATA_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               arm,
  input logic               busValid,
  input logic               cofFlag,
  input logic               freeCycle,
  input logic               opFetch,
  input logic               bufWrEn,
  input logic [PTR_W-1:0]   bufWrAddr,
  input logic               kindBit,
  input logic [PTR_W-1:0]   wrPtr,
  input logic [CNT_W-1:0]   validCount,
  input logic               sessionDone
);

  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(DEPTH);

  assert_arm_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (validCount == '0) && (wrPtr == '0) && !sessionDone && !bufWrEn);

  assert_cof_entry_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && !kindBit) |-> ($past(busValid) && $past(cofFlag)));

  assert_detail_excludes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && kindBit) |-> ($past(busValid) && !$past(freeCycle) && !$past(opFetch)));

  assert_ptr_follows_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (wrPtr == bufWrAddr + 1'b1));

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    validCount <= FULL_COUNT);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(arm) |-> ((validCount == $past(validCount)) ||
                     (validCount == $past(validCount) + 1'b1)));

  assert_no_write_when_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sessionDone && $past(sessionDone)) |-> !bufWrEn);

endmodule

bind bus_trace_recorder trace_cap_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .arm        (arm),
  .busValid   (busValid),
  .cofFlag    (cofFlag),
  .freeCycle  (freeCycle),
  .opFetch    (opFetch),
  .bufWrEn    (bufWrEn),
  .bufWrAddr  (bufWrAddr),
  .kindBit    (bufWrData[ENTRY_W-1]),
  .wrPtr      (wrPtr),
  .validCount (validCount),
  .sessionDone(sessionDone)
);

// File: tb/test_bus_trace_recorder.sv
module test_bus_trace_recorder;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int D  = 8;
  localparam int PW = $clog2(D);
  localparam int EW = 1 + AW + DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          arm = 1'b0;
  logic [1:0]    traceMode = 2'b00;
  logic [1:0]    align = 2'b00;
  logic          trigIn = 1'b0;
  logic          busValid = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic          cofFlag = 1'b0;
  logic          freeCycle = 1'b0;
  logic          opFetch = 1'b0;
  logic [AW-1:0] cofSrcAddr = '0;
  logic          bufWrEn;
  logic [PW-1:0] bufWrAddr;
  logic [EW-1:0] bufWrData;
  logic [PW-1:0] wrPtr;
  logic [PW:0]   validCount;
  logic          sessionDone;

  always #10 clk = ~clk;

  bus_trace_recorder #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D)) i_bus_trace_recorder (.*);

  int checks = 0;
  int errors = 0;

  // reference state: 0 idle, 1 wait, 2 pre, 3 post, 4 done
  int mSt = 0, mMode = 0, mAlign = 0, mPost = 0, mPtr = 0, mCount = 0;
  logic [AW-1:0] mLast = '0;
  bit mHistV = 0;
  bit expEn = 0;
  int expAddr = 0;
  logic [EW-1:0] expData = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit qualify(int mode);
    if (!busValid) return 0;
    if (mode == 2) return !freeCycle && !opFetch;
    if (mode == 1) return cofFlag && !(mHistV && cofSrcAddr == mLast);
    return cofFlag;
  endfunction

  function automatic string modeTag(int mode);
    return (mode == 2) ? "R4" : (mode == 1) ? "R3" : "R2";
  endfunction

  function automatic string alignTag(int al);
    return (al == 0) ? "R5" : (al == 1) ? "R6" : "R7";
  endfunction

  task automatic modelStep();
    bit q, open;
    int limit;
    q = qualify(mMode);
    if (arm) begin
      mSt = (align == 2'b00) ? 1 : 2;
      mMode = traceMode; mAlign = align;
      mPost = 0; mPtr = 0; mCount = 0; mHistV = 0; expEn = 0;
      return;
    end
    open = (mSt == 2) || (mSt == 3) || (mSt == 1 && trigIn);
    expEn = open && q;
    if (expEn) begin
      expAddr = mPtr;
      expData = (mMode == 2) ? {1'b1, busAddr, busData} : {1'b0, cofSrcAddr, busAddr};
      mPtr = (mPtr + 1) % D;
      if (mCount < D) mCount++;
      if (mMode == 1) begin mLast = cofSrcAddr; mHistV = 1; end
    end
    limit = (mAlign == 0) ? D : D / 2;
    case (mSt)
      1, 2: if (trigIn) begin
        if (mSt == 2 && mAlign >= 2) mSt = 4;
        else begin mPost = q ? 1 : 0; mSt = (q && limit == 1) ? 4 : 3; end
      end
      3: if (q) begin mPost++; if (mPost == limit) mSt = 4; end
      default: ;
    endcase
  endtask

  task automatic compareAll();
    string mt, at;
    mt = modeTag(mMode);
    at = alignTag(mAlign);
    check(bufWrEn === expEn, mt, "bufWrEn", bufWrEn, expEn);
    if (expEn) begin
      check(bufWrAddr === PW'(expAddr), "R8", "bufWrAddr", bufWrAddr, expAddr);
      check(bufWrData === expData, mt, "bufWrData", bufWrData, expData);
    end
    check(wrPtr === PW'(mPtr), "R8", "wrPtr", wrPtr, mPtr);
    check(validCount === (PW+1)'(mCount), "R8", "validCount", validCount, mCount);
    check(sessionDone === (mSt == 4), at, "sessionDone", sessionDone, mSt == 4);
  endtask

  task automatic randomBus();
    busValid   = ($urandom % 10) < 8;
    cofFlag    = ($urandom % 10) < 4;
    freeCycle  = ($urandom % 10) < 2;
    opFetch    = ($urandom % 10) < 3;
    busAddr    = AW'($urandom);
    busData    = DW'($urandom);
    cofSrcAddr = AW'(16'h1000 + ($urandom % 4));
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    modelStep();
    compareAll();
    @(negedge clk);
  endtask

  task automatic runSession(input int mode, input int al, input int trigAt);
    @(negedge clk);
    traceMode = 2'(mode); align = 2'(al);
    arm = 1'b1; trigIn = 1'b0; randomBus();
    cycle();
    arm = 1'b0;
    check(sessionDone === 1'b0, "R9", "done cleared by arm", sessionDone, 0);
    for (int i = 0; i < 90; i++) begin
      randomBus();
      // R10: settings may change mid-session without effect
      traceMode = 2'($urandom); align = 2'($urandom);
      trigIn = (i == trigAt) || (($urandom % 16) == 0 && i > trigAt);
      cycle();
      if (mSt == 4 && i > trigAt + 2) break;
    end
    // R10: trigger and bus activity after done change nothing
    for (int i = 0; i < 3; i++) begin
      randomBus(); busValid = 1'b1; cofFlag = 1'b1; freeCycle = 1'b0; opFetch = 1'b0;
      trigIn = 1'b1;
      cycle();
      check(!(bufWrEn && mSt == 4), "R10", "write after done", bufWrEn, 0);
    end
    trigIn = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    #1;
    check(bufWrEn === 1'b0 && wrPtr === '0 && validCount === '0 && sessionDone === 1'b0 &&
          bufWrData === '0 && bufWrAddr === '0, "R1", "reset outputs",
          {bufWrEn, wrPtr, validCount, sessionDone}, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1/R10: idle with trigger and cof activity stores nothing
    for (int i = 0; i < 6; i++) begin
      randomBus(); busValid = 1'b1; cofFlag = 1'b1; trigIn = 1'b1;
      cycle();
    end
    check(validCount === '0, "R1", "idle count", validCount, 0);
    trigIn = 1'b0;

    // directed R3: repeated source suppressed, first after arm stored
    @(negedge clk);
    traceMode = 2'b01; align = 2'b10; arm = 1'b1;
    cycle();
    arm = 1'b0;
    for (int i = 0; i < 4; i++) begin
      busValid = 1'b1; cofFlag = 1'b1; freeCycle = 1'b0; opFetch = 1'b0;
      cofSrcAddr = (i < 3) ? 16'h2222 : 16'h3333; busAddr = AW'(i);
      cycle();
    end
    check(validCount === 4'd2, "R3", "loop suppression count", validCount, 2);
    busValid = 1'b0; trigIn = 1'b1;
    cycle();
    trigIn = 1'b0;
    check(sessionDone === 1'b1, "R7", "end stops at trigger", sessionDone, 1);

    for (int rep = 0; rep < 3; rep++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 4; a++)
          runSession(m, a, 2 + ($urandom % 30));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule